// File: doc/BRIEF.md
# Blanking-Run Sync Regenerator

This block serves a video input that delivers a data-enable signal and pixels but no horizontal or vertical sync. It rebuilds both syncs from the blanking alone. Every pixel clock with data-enable low counts as an empty pixel. The block counts unbroken runs of empty pixels and compares the running length against two programmable thresholds. A run that reaches the shorter threshold is a line gap. A run that also reaches the longer threshold is a frame gap. Downstream capture logic can then keep lines and frames in the right order.

The block emits one-cycle line and frame sync pulses while the blanking run is still in progress. On the first active pixel after a gap it emits one-cycle start-of-line and start-of-frame markers, aligned with that pixel. It also checks the two thresholds on every clock. If they do not make sense, it raises an error flag and suppresses all sync output until they are corrected.

Top module: `syncgap_regen`

## Requirements
- R1: The empty-pixel run length returns to zero on every pixel with data-enable high. It rises by one on every pixel with data-enable low and saturates at 2^GAP_W-1. A run broken by an active pixel restarts from zero.
- R2: `hsyncOut` is high for exactly the one clock after the edge that samples the empty pixel whose run length equals `lineGapLen`.
- R3: `vsyncOut` is high for exactly the one clock after the edge that samples the empty pixel whose run length equals `frameGapLen`. In a valid configuration it never coincides with `hsyncOut`.
- R4: Each sync pulse fires at most once per blanking run, including runs that continue past the threshold or stay at the saturated count.
- R5: The configuration is valid only when `lineGapLen` > 1 and `lineGapLen` < `frameGapLen`. `configError` shows the inverse of that test, one clock after the edge that samples the thresholds.
- R6: While the configuration is invalid, no sync pulse and no marker is produced, and any start marker still owed is discarded.
- R7: `lineStart` is high for one clock after the first data-enable-high pixel that follows a run which produced a line or frame sync pulse.
- R8: `frameStart` is high for one clock after the first data-enable-high pixel that follows a run which produced a frame sync pulse. It is always accompanied by `lineStart`.
- R9: While `rstN` is low, all outputs are low and the run length is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataEn | input | 1 | Data-enable of the incoming pixel stream, high on active pixels |
| lineGapLen | input | GAP_W | Empty-pixel run length that marks a line gap |
| frameGapLen | input | GAP_W | Empty-pixel run length that marks a frame gap |
| hsyncOut | output | 1 | Regenerated line sync pulse |
| vsyncOut | output | 1 | Regenerated frame sync pulse |
| lineStart | output | 1 | Start-of-line marker on the first active pixel after a gap |
| frameStart | output | 1 | Start-of-frame marker on the first active pixel after a frame gap |
| configError | output | 1 | Threshold pair is invalid |

## Verification
Each output is a single register stage behind the pixel edge that causes it. A sync pulse, a marker or the error flag for a given pixel is therefore visible during exactly the clock period after that pixel is sampled. The bench drives each pixel and the thresholds on a falling edge. At the next falling edge it compares all five outputs with a model that walks the same pixel sequence. That comparison falls half a period after the responsible rising edge and before the following one. The sweep covers every threshold pair of a 4-bit configuration. For each pair it applies gap lengths from one pixel up to beyond saturation, so runs that are short, exact, long and saturated all meet valid and invalid settings.

// File: rtl/syncgap_pkg.sv
package syncgap_pkg;

  // Strobes from control to the run-length datapath
  typedef struct packed {
    logic clearCnt;
    logic stepCnt;
  } gap_cmd_t;

  // Threshold events reported back by the datapath
  typedef struct packed {
    logic lineHit;
    logic frameHit;
  } gap_hit_t;

endpackage

// File: rtl/syncgap_counter.sv
module syncgap_counter
  import syncgap_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             pixClk,
  input  logic             rstN,
  input  gap_cmd_t         cmd,
  input  logic [GAP_W-1:0] lineGapLen,
  input  logic [GAP_W-1:0] frameGapLen,
  output gap_hit_t         hit
);

  localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] nextCnt;
  logic             atCeiling;

  assign nextCnt   = gapCnt + 1'b1;
  assign atCeiling = (gapCnt == CNT_MAX);

  // A threshold is met only on the pixel that moves the count onto it
  always_comb begin
    hit.lineHit  = cmd.stepCnt && !atCeiling && (nextCnt == lineGapLen);
    hit.frameHit = cmd.stepCnt && !atCeiling && (nextCnt == frameGapLen);
  end

  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (cmd.clearCnt) begin
      gapCnt <= '0;
    end else if (cmd.stepCnt && !atCeiling) begin
      gapCnt <= nextCnt;
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge pixClk) disable iff (!rstN)
    $past(cmd.clearCnt) |-> (gapCnt == '0)); // R1

  AST_CNT_HOLDS_IDLE: assert property (@(posedge pixClk) disable iff (!rstN)
    (!$past(cmd.clearCnt) && !$past(cmd.stepCnt)) |-> $stable(gapCnt)); // R1

  AST_CNT_RESET: assert property (@(posedge pixClk)
    !rstN |-> (gapCnt == '0)); // R9

endmodule

// File: rtl/syncgap_ctrl.sv
module syncgap_ctrl
  import syncgap_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             pixClk,
  input  logic             rstN,
  input  logic             dataEn,
  input  logic [GAP_W-1:0] lineGapLen,
  input  logic [GAP_W-1:0] frameGapLen,
  input  gap_hit_t         hit,
  output gap_cmd_t         cmd,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             lineStart,
  output logic             frameStart,
  output logic             configError
);

  logic cfgOk;
  logic linePend;
  logic framePend;

  // Line gap must exceed one pixel and stay below the frame gap
  assign cfgOk = (lineGapLen > GAP_W'(1)) && (lineGapLen < frameGapLen);

  always_comb begin
    cmd.clearCnt = dataEn;
    cmd.stepCnt  = !dataEn;
  end

  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut    <= 1'b0;
      vsyncOut    <= 1'b0;
      lineStart   <= 1'b0;
      frameStart  <= 1'b0;
      configError <= 1'b0;
      linePend    <= 1'b0;
      framePend   <= 1'b0;
    end else begin
      configError <= !cfgOk;
      hsyncOut    <= cfgOk && hit.lineHit;
      vsyncOut    <= cfgOk && hit.frameHit;
      lineStart   <= cfgOk && dataEn && linePend;
      frameStart  <= cfgOk && dataEn && framePend;
      if (!cfgOk || dataEn) begin
        linePend  <= 1'b0;
        framePend <= 1'b0;
      end else begin
        if (hit.lineHit || hit.frameHit) linePend  <= 1'b1;
        if (hit.frameHit)                framePend <= 1'b1;
      end
    end
  end

  AST_HSYNC_SINGLE: assert property (@(posedge pixClk) disable iff (!rstN)
    hsyncOut |=> !hsyncOut); // R4

  AST_VSYNC_SINGLE: assert property (@(posedge pixClk) disable iff (!rstN)
    vsyncOut |=> !vsyncOut); // R4

  AST_SYNC_EXCLUSIVE: assert property (@(posedge pixClk) disable iff (!rstN)
    !(hsyncOut && vsyncOut)); // R3

  AST_QUIET_ON_ERROR: assert property (@(posedge pixClk) disable iff (!rstN)
    configError |-> !(hsyncOut || vsyncOut || lineStart || frameStart)); // R6

  AST_MARKER_NOT_IN_GAP: assert property (@(posedge pixClk) disable iff (!rstN)
    lineStart |-> !(hsyncOut || vsyncOut)); // R7

  AST_FRAME_WITH_LINE: assert property (@(posedge pixClk) disable iff (!rstN)
    frameStart |-> lineStart); // R8

  AST_MARKER_SINGLE: assert property (@(posedge pixClk) disable iff (!rstN)
    lineStart |=> !lineStart); // R7

endmodule

// File: rtl/syncgap_regen.sv
module syncgap_regen
  import syncgap_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             pixClk,
  input  logic             rstN,
  input  logic             dataEn,
  input  logic [GAP_W-1:0] lineGapLen,
  input  logic [GAP_W-1:0] frameGapLen,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             lineStart,
  output logic             frameStart,
  output logic             configError
);

  gap_cmd_t gapCmd;
  gap_hit_t gapHit;

  syncgap_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .pixClk      (pixClk),
    .rstN        (rstN),
    .dataEn      (dataEn),
    .lineGapLen  (lineGapLen),
    .frameGapLen (frameGapLen),
    .hit         (gapHit),
    .cmd         (gapCmd),
    .hsyncOut    (hsyncOut),
    .vsyncOut    (vsyncOut),
    .lineStart   (lineStart),
    .frameStart  (frameStart),
    .configError (configError)
  );

  syncgap_counter #(.GAP_W(GAP_W)) u_counter (
    .pixClk      (pixClk),
    .rstN        (rstN),
    .cmd         (gapCmd),
    .lineGapLen  (lineGapLen),
    .frameGapLen (frameGapLen),
    .hit         (gapHit)
  );

  AST_RESET_QUIET: assert property (@(posedge pixClk)
    !rstN |-> !(hsyncOut || vsyncOut || lineStart || frameStart || configError)); // R9

endmodule

// File: tb/syncgap_regen_bench.sv
module syncgap_regen_bench;

  localparam int GAP_W = 4;
  localparam int CMAX  = (1 << GAP_W) - 1;

  logic             pixClk = 1'b0;
  logic             rstN   = 1'b0;
  logic             dataEn = 1'b1;
  logic [GAP_W-1:0] lineGapLen  = '0;
  logic [GAP_W-1:0] frameGapLen = '0;
  logic hsyncOut, vsyncOut, lineStart, frameStart, configError;

  int vecCount = 0;
  int badCount = 0;
  int mCnt = 0;
  bit mPendL = 0;
  bit mPendF = 0;
  bit finished = 0;

  always #2.5 pixClk = ~pixClk;

  syncgap_regen #(.GAP_W(GAP_W)) u_syncgap_regen (
    .pixClk      (pixClk),
    .rstN        (rstN),
    .dataEn      (dataEn),
    .lineGapLen  (lineGapLen),
    .frameGapLen (frameGapLen),
    .hsyncOut    (hsyncOut),
    .vsyncOut    (vsyncOut),
    .lineStart   (lineStart),
    .frameStart  (frameStart),
    .configError (configError)
  );

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one pixel at a falling edge; check its results at the next one
  task automatic pixel(input bit de, input string forceTag);
    bit ok, eH, eV, eLS, eFS;
    string tH, tV, tM;
    ok = (int'(lineGapLen) > 1) && (int'(lineGapLen) < int'(frameGapLen));
    eH = 0; eV = 0; eLS = 0; eFS = 0;
    tH = ok ? "R2" : "R6";
    tV = ok ? "R3" : "R6";
    tM = ok ? "R7" : "R6";
    if (de) begin
      eLS = ok && mPendL;
      eFS = ok && mPendF;
      mCnt = 0; mPendL = 0; mPendF = 0;
    end else begin
      if (ok && mCnt >= int'(lineGapLen)) tH = "R4";
      if (ok && mCnt >= int'(frameGapLen)) tV = "R4";
      eH = ok && (mCnt < CMAX) && (mCnt + 1 == int'(lineGapLen));
      eV = ok && (mCnt < CMAX) && (mCnt + 1 == int'(frameGapLen));
      if (mCnt < CMAX) mCnt++;
      if (eH || eV) mPendL = 1;
      if (eV) mPendF = 1;
    end
    if (!ok) begin mPendL = 0; mPendF = 0; end
    if (forceTag != "") begin tH = forceTag; tV = forceTag; tM = forceTag; end
    dataEn = de;
    @(negedge pixClk);
    vecCount++;
    chk(hsyncOut,    eH,  tH, "hsyncOut");
    chk(vsyncOut,    eV,  tV, "vsyncOut");
    chk(lineStart,   eLS, tM, "lineStart");
    chk(frameStart,  eFS, ok ? "R8" : "R6", "frameStart");
    chk(configError, !ok, "R5", "configError");
  endtask

  task automatic run(input int lows, input int highs, input string tag);
    for (int i = 0; i < lows; i++)  pixel(1'b0, tag);
    for (int i = 0; i < highs; i++) pixel(1'b1, tag);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      badCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs low even with a long blanking run applied
    dataEn = 1'b0; lineGapLen = 4'd2; frameGapLen = 4'd3;
    repeat (6) @(negedge pixClk);
    vecCount++;
    chk(hsyncOut,    0, "R9", "hsyncOut");
    chk(vsyncOut,    0, "R9", "vsyncOut");
    chk(lineStart,   0, "R9", "lineStart");
    chk(frameStart,  0, "R9", "frameStart");
    chk(configError, 0, "R9", "configError");
    rstN = 1'b1;
    dataEn = 1'b1;

    // R9: the count starts at zero, so the line pulse needs a full run
    lineGapLen = 4'd3; frameGapLen = 4'd6;
    run(0, 2, "R9");
    run(3, 1, "R9");
    // R1: interrupted runs restart from zero, so no pulse for 2+2
    run(2, 1, "R1");
    run(2, 1, "R1");
    run(5, 2, "R1");
    // R8: full frame gap gives both markers
    run(7, 2, "R8");

    // Sweep every threshold pair with gap lengths up to past saturation
    for (int l = 0; l <= CMAX; l++) begin
      for (int f = 0; f <= CMAX; f++) begin
        lineGapLen  = GAP_W'(l);
        frameGapLen = GAP_W'(f);
        for (int g = 1; g <= CMAX + 4; g++) run(g, 1, "");
        run(0, 1, "");
      end
    end

    // R6: thresholds made invalid mid-gap discard the owed markers
    lineGapLen = 4'd2; frameGapLen = 4'd4;
    run(5, 0, "R6");
    lineGapLen = 4'd5;
    run(0, 2, "R6");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

endmodule